// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block brings a DDR2 SDRAM from power-on to an operational state. After a synchronous reset it holds the memory clock enable low for a long, parameterized settling period. It then raises clock enable and waits a short interval. After that it issues a fixed series of precharge, mode-register-load and auto-refresh commands, each spaced by a parameterized minimum gap. The block drives the chip-select and RAS/CAS/WE strobes, the bank address and the row address directly. Every output is registered.

The operating values written into the mode registers are parameters: CAS latency, burst length and write recovery. So are the long power-up count, the minimum gaps after mode loads, precharges and refreshes, and the wait the memory needs after its DLL is reset. A single down-counter, reloaded as each step is issued, times every wait. When the last extended-mode load has had its gap, `init_done` rises and stays high until the next reset, and the command bus then idles.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is high and afterwards until the PWRUP_CYC-th rising edge after reset release, `mem_cke` is low and the bus carries NOP. On that edge `mem_cke` goes high and stays high until reset.
- R2: The first command is a precharge-all, issued max(1, PWRUP_CYC/500) cycles after `mem_cke` rises, with bank 0 and only address bit AP_BIT set.
- R3: Commands on {cs_n, ras_n, cas_n, we_n} are encoded as NOP = 0111, precharge = 0010, auto-refresh = 0001 and mode-register load = 0000.
- R4: Next come two mode-register loads with all-zero address: bank 2, issued T_RP after the precharge, then bank 3, issued T_MRD later.
- R5: T_MRD later, bank 1 is loaded with all-zero address, which enables the memory DLL.
- R6: T_MRD later, bank 0 is loaded with burst code on address bits 2:0 (2 for burst 4, 3 for burst 8), CAS latency on bits 6:4, DLL reset on bit 8 and write recovery minus one on bits 11:9.
- R7: T_MRD later a second precharge-all is issued. It is followed T_RP later by an auto-refresh, and T_RFC after that by a second auto-refresh.
- R8: T_RFC after the second refresh, bank 0 is loaded again with the R6 value but with bit 8 clear.
- R9: Bank 1 is loaded with address bits 9:7 all set (OCD default) max(DLL_WAIT, T_MRD+T_RP+2*T_RFC+T_MRD) cycles after the DLL-reset load. T_MRD later it is loaded with zero (OCD exit).
- R10: `init_done` rises T_MRD cycles after the final bank 1 load and stays high, with NOP on the bus, until reset. Reset clears it.
- R11: Exactly eleven non-NOP commands are issued, and every other cycle carries NOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ROW_W | Row address / mode-register data |
| init_done | output | 1 | Initialization finished, sticky |

## Verification
The main instance is built with PWRUP_CYC = 1000, which gives a two-cycle pre-precharge wait. It uses tMRD 2, tRP 3, tRFC 8, CAS latency 4, burst 8 and write recovery 3, so the whole sequence ends in about 1,220 cycles. Every command, bank, address and issue cycle can then be compared against a table. With DLL_WAIT = 200, the DLL wait is the binding rule for the gap before the OCD-default load. A second instance with PWRUP_CYC = 100 makes the division by 500 yield zero, which exercises the one-cycle minimum on the pre-precharge wait.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_NOP = 4'b0111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWRUP, ST_PRE1, ST_EMR2, ST_EMR3, ST_EMR1, ST_MRDLL, ST_PRE2,
    ST_REF1, ST_REF2, ST_MR, ST_OCD1, ST_OCD2, ST_FIN, ST_DONE
  } step_e;

endpackage

// File: rtl/init_wait_ctr.sv
module init_wait_ctr #(
  parameter int CW      = 16,
  parameter int RST_VAL = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= CW'(RST_VAL);
    else if (load_i)      cnt <= load_val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);

  // An expired wait never wraps back into a non-zero count by itself (R11)
  p_no_wrap_r11: assert property (@(posedge clk) disable iff (rst)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/init_cmd_reg.sv
module init_cmd_reg
  import ddr2_init_pkg::*;
#(
  parameter int BA_W  = 3,
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_i,
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [ROW_W-1:0] addr_i,
  input  logic             cke_set_i,
  input  logic             done_set_i,
  output logic [3:0]       cmd_q,
  output logic [BA_W-1:0]  ba_q,
  output logic [ROW_W-1:0] addr_q,
  output logic             cke_q,
  output logic             done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (issue_i) begin
        cmd_q  <= cmd_i;
        ba_q   <= ba_i;
        addr_q <= addr_i;
      end else begin
        cmd_q  <= CMD_NOP;
        ba_q   <= '0;
        addr_q <= '0;
      end
      if (cke_set_i)  cke_q  <= 1'b1;
      if (done_set_i) done_q <= 1'b1;
    end
  end

  p_nop_while_cke_low_r1: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> cmd_q == CMD_NOP);
  p_cke_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    cke_q |=> cke_q);
  p_done_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);
  p_quiet_after_done_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> cmd_q == CMD_NOP);
  p_done_needs_cke_r10: assert property (@(posedge clk) disable iff (rst)
    done_q |-> cke_q);
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int PWRUP_CYC = 50000,
  parameter int T_MRD     = 2,
  parameter int T_RP      = 4,
  parameter int T_RFC     = 32,
  parameter int DLL_WAIT  = 200,
  parameter int CAS_LAT   = 4,
  parameter int BURST_LEN = 8,
  parameter int WR_REC    = 3,
  parameter int AP_BIT    = 10,
  parameter int BA_W      = 3,
  parameter int ROW_W     = 14
) (
  input  logic             clk,
  input  logic             rst,
  output logic             mem_cke,
  output logic             mem_cs_n,
  output logic             mem_ras_n,
  output logic             mem_cas_n,
  output logic             mem_we_n,
  output logic [BA_W-1:0]  mem_ba,
  output logic [ROW_W-1:0] mem_addr,
  output logic             init_done
);
  localparam int PRE_WAIT  = (PWRUP_CYC / 500 < 1) ? 1 : PWRUP_CYC / 500;
  localparam int SPAN      = T_MRD + T_RP + 2 * T_RFC;
  localparam int MR_TO_OCD = (DLL_WAIT - SPAN >= T_MRD) ? DLL_WAIT - SPAN : T_MRD;
  localparam int MAXV      = (PWRUP_CYC > DLL_WAIT) ? PWRUP_CYC : DLL_WAIT;
  localparam int CW        = $clog2(MAXV + 1) + 1;
  localparam int BL_CODE   = (BURST_LEN == 8) ? 3 : 2;
  localparam logic [ROW_W-1:0] MR_RUN =
      ROW_W'(BL_CODE) | ROW_W'(CAS_LAT << 4) | ROW_W'((WR_REC - 1) << 9);
  localparam logic [ROW_W-1:0] MR_DLLRST = MR_RUN | ROW_W'(1 << 8);
  localparam logic [ROW_W-1:0] OCD_DFLT  = ROW_W'(7 << 7);
  localparam logic [ROW_W-1:0] AP_MASK   = ROW_W'(1 << AP_BIT);

  step_e            step, nxt;
  cmd_e             act_cmd;
  logic [BA_W-1:0]  act_ba;
  logic [ROW_W-1:0] act_addr;
  int               gap;
  logic             set_cke, set_done, ctr_zero, fire;
  logic [3:0]       cmd_q;

  always_comb begin
    nxt = step; act_cmd = CMD_NOP; act_ba = '0; act_addr = '0;
    gap = 1; set_cke = 1'b0; set_done = 1'b0;
    unique case (step)
      ST_PWRUP: begin set_cke = 1'b1; gap = PRE_WAIT; nxt = ST_PRE1; end
      ST_PRE1:  begin act_cmd = CMD_PRE; act_addr = AP_MASK; gap = T_RP; nxt = ST_EMR2; end
      ST_EMR2:  begin act_cmd = CMD_MRS; act_ba = BA_W'(2); gap = T_MRD; nxt = ST_EMR3; end
      ST_EMR3:  begin act_cmd = CMD_MRS; act_ba = BA_W'(3); gap = T_MRD; nxt = ST_EMR1; end
      ST_EMR1:  begin act_cmd = CMD_MRS; act_ba = BA_W'(1); gap = T_MRD; nxt = ST_MRDLL; end
      ST_MRDLL: begin act_cmd = CMD_MRS; act_addr = MR_DLLRST; gap = T_MRD; nxt = ST_PRE2; end
      ST_PRE2:  begin act_cmd = CMD_PRE; act_addr = AP_MASK; gap = T_RP; nxt = ST_REF1; end
      ST_REF1:  begin act_cmd = CMD_REF; gap = T_RFC; nxt = ST_REF2; end
      ST_REF2:  begin act_cmd = CMD_REF; gap = T_RFC; nxt = ST_MR; end
      ST_MR:    begin act_cmd = CMD_MRS; act_addr = MR_RUN; gap = MR_TO_OCD; nxt = ST_OCD1; end
      ST_OCD1:  begin act_cmd = CMD_MRS; act_ba = BA_W'(1); act_addr = OCD_DFLT; gap = T_MRD; nxt = ST_OCD2; end
      ST_OCD2:  begin act_cmd = CMD_MRS; act_ba = BA_W'(1); gap = T_MRD; nxt = ST_FIN; end
      ST_FIN:   begin set_done = 1'b1; nxt = ST_DONE; end
      ST_DONE:  nxt = ST_DONE;
      default:  nxt = ST_DONE;
    endcase
  end

  assign fire = ctr_zero && (step != ST_DONE);

  always_ff @(posedge clk) begin
    if (rst)       step <= ST_PWRUP;
    else if (fire) step <= nxt;
  end

  init_wait_ctr #(.CW(CW), .RST_VAL(PWRUP_CYC - 1)) u_wait (
    .clk(clk), .rst(rst), .load_i(fire),
    .load_val_i(CW'(gap - 1)), .zero_o(ctr_zero));

  init_cmd_reg #(.BA_W(BA_W), .ROW_W(ROW_W)) u_out (
    .clk(clk), .rst(rst), .issue_i(fire), .cmd_i(act_cmd),
    .ba_i(act_ba), .addr_i(act_addr), .cke_set_i(fire && set_cke),
    .done_set_i(fire && set_done), .cmd_q(cmd_q), .ba_q(mem_ba),
    .addr_q(mem_addr), .cke_q(mem_cke), .done_q(init_done));

  assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd_q;

  p_pre_all_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_PRE) |-> (mem_addr[AP_BIT] && mem_ba == '0));
  p_legal_code_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_q inside {CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS});
  p_refresh_quiet_addr_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_REF) |-> (mem_addr == '0 && mem_ba == '0));
  p_high_bank_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_q == CMD_MRS && mem_ba[1]) |-> mem_addr == '0);
endmodule

// File: tb/ddr2_init_seq_test.sv
module ddr2_init_seq_test;
  localparam int PW = 1000, MRD = 2, RP = 3, RFC = 8, DW = 200;
  localparam int NCMD = 11;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;
  localparam int C0 = PW + 2;                // first precharge, R2
  localparam int CD = C0 + RP + 3 * MRD;     // DLL-reset load
  localparam int CM = CD + MRD + RP + 2 * RFC;

  localparam logic [3:0]  EXP_CMD [NCMD] = '{PRE, MRS, MRS, MRS, MRS, PRE, REF, REF, MRS, MRS, MRS};
  localparam logic [2:0]  EXP_BA  [NCMD] = '{0, 2, 3, 1, 0, 0, 0, 0, 0, 1, 1};
  localparam logic [13:0] EXP_ADR [NCMD] = '{14'h400, 0, 0, 0, 14'h543, 14'h400, 0, 0, 14'h443, 14'h380, 0};
  localparam int EXP_CYC [NCMD] = '{C0, C0+RP, C0+RP+MRD, C0+RP+2*MRD, CD, CD+MRD, CD+MRD+RP,
                                    CD+MRD+RP+RFC, CM, CD+DW, CD+DW+MRD};
  // requirement of each row: R2, R4, R4, R5, R6, R7, R7, R7, R8, R9, R9
  localparam int EXP_REQ [NCMD] = '{2, 4, 4, 5, 6, 7, 7, 7, 8, 9, 9};

  logic clk = 1'b0, rst = 1'b1;
  always #2 clk = ~clk;

  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [2:0] ba; logic [13:0] addr;
  logic s_cke, s_cs_n, s_ras_n, s_cas_n, s_we_n, s_done;
  logic [2:0] s_ba; logic [13:0] s_addr;

  ddr2_init_seq #(.PWRUP_CYC(PW), .T_MRD(MRD), .T_RP(RP), .T_RFC(RFC), .DLL_WAIT(DW),
    .CAS_LAT(4), .BURST_LEN(8), .WR_REC(3), .AP_BIT(10), .BA_W(3), .ROW_W(14)) uut (
    .clk(clk), .rst(rst), .mem_cke(cke), .mem_cs_n(cs_n), .mem_ras_n(ras_n),
    .mem_cas_n(cas_n), .mem_we_n(we_n), .mem_ba(ba), .mem_addr(addr), .init_done(done));

  ddr2_init_seq #(.PWRUP_CYC(100), .T_MRD(MRD), .T_RP(RP), .T_RFC(RFC), .DLL_WAIT(DW),
    .BA_W(3), .ROW_W(14)) uut_short (
    .clk(clk), .rst(rst), .mem_cke(s_cke), .mem_cs_n(s_cs_n), .mem_ras_n(s_ras_n),
    .mem_cas_n(s_cas_n), .mem_we_n(s_we_n), .mem_ba(s_ba), .mem_addr(s_addr), .init_done(s_done));

  int cyc = 0, n_chk = 0, n_fail = 0;
  int n_log = 0, cke_cyc = -1, done_cyc = -1, s_cke_cyc = -1, s_cmd_cyc = -1, late_cmds = 0;
  logic [3:0] log_cmd [16]; logic [2:0] log_ba [16]; logic [13:0] log_adr [16]; int log_cyc [16];

  always @(posedge clk) cyc <= rst ? 0 : cyc + 1;

  always @(negedge clk) if (!rst) begin
    if (cke && cke_cyc < 0) cke_cyc = cyc;
    if (done && done_cyc < 0) done_cyc = cyc;
    if (s_cke && s_cke_cyc < 0) s_cke_cyc = cyc;
    if ({s_cs_n, s_ras_n, s_cas_n, s_we_n} != NOP && s_cmd_cyc < 0) s_cmd_cyc = cyc;
    if ({cs_n, ras_n, cas_n, we_n} != NOP) begin
      if (done) late_cmds++;
      if (n_log < 16) begin
        log_cmd[n_log] = {cs_n, ras_n, cas_n, we_n}; log_ba[n_log] = ba;
        log_adr[n_log] = addr; log_cyc[n_log] = cyc;
      end
      n_log++;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 reset state", {cke, cs_n, ras_n, cas_n, we_n, done}, {1'b0, NOP, 1'b0});
    rst = 1'b0;
    repeat (PW - 1) @(negedge clk);
    chk("R1 cke low before count", {cke, cs_n, ras_n, cas_n, we_n}, {1'b0, NOP});
    repeat (CD + DW + 60 - PW) @(negedge clk);

    chk("R1 cke rise cycle", cke_cyc, PW);
    chk("R11 command count", n_log, NCMD);
    for (int i = 0; i < NCMD; i++) begin
      if (i < n_log)
        chk($sformatf("R%0d table row %0d", EXP_REQ[i], i),
            {log_cmd[i], log_ba[i], log_adr[i], 32'(log_cyc[i])},
            {EXP_CMD[i], EXP_BA[i], EXP_ADR[i], 32'(EXP_CYC[i])});
    end
    chk("R3 mode-load code", log_cmd[1], 4'b0000);
    chk("R10 done rise cycle", done_cyc, CD + DW + 2 * MRD);
    chk("R10 done held, bus quiet", {done, late_cmds[7:0], cs_n, ras_n, cas_n, we_n}, {1'b1, 8'd0, NOP});
    chk("R2 minimum one-cycle wait", {32'(s_cke_cyc), 32'(s_cmd_cyc)}, {32'd100, 32'd101});

    @(negedge clk) rst = 1'b1;
    @(negedge clk);
    chk("R10 reset clears done", {done, cke}, 2'b00);
    chk("R1 reset forces NOP", {cs_n, ras_n, cas_n, we_n}, NOP);
    finish_run();
  end
endmodule